// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind the serial slave engine of a byte-wide non-volatile memory arranged as 512 pages of 64 bytes. A write transaction first loads a 15-bit address (page number in the upper nine bits, byte slot in the lower six). Each data byte received after that lands in a 64-slot page buffer. A per-slot valid flag records which slots were actually received. Only the six-bit slot pointer advances between bytes, so a long transaction wraps around inside its own page and overwrites its own earlier bytes.

When the engine reports the stop that ends a write, the block starts a self-timed write cycle, provided at least one byte was collected and write protection is off. During that cycle it walks the buffer once and writes every valid slot to the array through a simple write port. It holds `busy_out` high for a fixed number of clock cycles. The slave engine withholds every acknowledge while `busy_out` is high, and that gives the host acknowledge polling. While busy, the block ignores every strobe it receives. With protection on, the collected bytes are dropped at the stop and no busy period occurs.

Top module: `pgw_page_commit`

## Requirements
- R1: After reset `busy_out` and `mem_we` are low and the buffer holds no bytes.
- R2: A data byte is stored for array address {page, slot}. Page and slot come from the last address load (page = `addr_in[14:6]`, slot = `addr_in[5:0]`). After each byte only the slot advances by one and the page never changes.
- R3: The slot after 63 is slot 0 of the same page. A transaction of more than 64 bytes therefore leaves the last byte sent for each slot.
- R4: A commit writes each slot received in the transaction exactly once and writes no other slot.
- R5: A stop strobe with at least one buffered byte and `wp_in` low raises `busy_out` on the next clock edge. `busy_out` then stays high for exactly CYCLE_CLKS cycles.
- R6: A stop strobe with no buffered byte leaves `busy_out` low and causes no array write.
- R7: A stop strobe while `wp_in` is high leaves `busy_out` low, causes no array write and discards the buffered bytes, so a later stop commits nothing.
- R8: While `busy_out` is high, address loads, data bytes and stop strobes have no effect.
- R9: `mem_we` is asserted only while `busy_out` is high and only within the first 64 cycles of the busy period.
- R10: An address load discards any bytes not yet committed and starts a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | One-cycle strobe: take `addr_in` as page and slot |
| addr_in | input | 15 | Page number [14:6] and byte slot [5:0] |
| byte_strobe | input | 1 | One-cycle strobe: a data byte was received |
| byte_in | input | 8 | Received data byte |
| stop_strobe | input | 1 | One-cycle strobe: stop condition ended the transaction |
| wp_in | input | 1 | High inhibits all array writes |
| busy_out | output | 1 | Write cycle in progress; acknowledges must be withheld |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench keeps the default 9-bit page and 6-bit slot widths but shortens CYCLE_CLKS to 100 cycles. A full commit, including the busy length check, then fits in about a hundred cycles, so dozens of random transactions can run. Some of these strobe addresses, bytes and stops into the busy window. The short cycle still exceeds 64, so the scan of the whole buffer and the idle tail of the busy period both occur in every commit.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [0:0] {
    CYC_IDLE = 1'b0,
    CYC_RUN  = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/pgw_slot_ptr.sv
module pgw_slot_ptr #(
  parameter int PAGE_W = 9,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [WORD_W-1:0] load_word,
  input  logic              step_en,
  output logic [PAGE_W-1:0] page_q,
  output logic [WORD_W-1:0] word_q
);
  logic [PAGE_W-1:0] page_d;
  logic [WORD_W-1:0] word_d;

  // slot pointer wraps in WORD_W bits; page held until next load
  always_comb begin
    page_d = page_q;
    word_d = word_q;
    if (load_en) begin
      page_d = load_page;
      word_d = load_word;
    end else if (step_en) begin
      word_d = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      word_q <= '0;
    end else begin
      page_q <= page_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/pgw_slot_store.sv
module pgw_slot_store #(
  parameter int WORD_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << WORD_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  valid_q;
  logic [SLOTS-1:0]  valid_d;

  always_comb begin
    valid_d = valid_q;
    if (clr)        valid_d = '0;
    else if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // data slots carry no reset: they are read only under their valid flag
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == WORD_W'(g));
    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end
  end

  assign rd_data   = slot_q[rd_idx];
  assign rd_valid  = valid_q[rd_idx];
  assign any_valid = |valid_q;
endmodule

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer
  import pgw_pkg::*;
#(
  parameter int CYCLE_CLKS = 250000,
  parameter int CNT_W      = $clog2(CYCLE_CLKS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  cyc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_d;

  assign busy = (st_q == CYC_RUN);
  assign done = busy && (count == LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = count;
    if (st_q == CYC_IDLE) begin
      if (start) begin
        st_d  = CYC_RUN;
        cnt_d = '0;
      end
    end else if (done) begin
      st_d  = CYC_IDLE;
      cnt_d = '0;
    end else begin
      cnt_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CYC_IDLE;
      count <= '0;
    end else begin
      st_q  <= st_d;
      count <= cnt_d;
    end
  end
endmodule

// File: rtl/pgw_page_commit.sv
module pgw_page_commit #(
  parameter int PAGE_W     = 9,
  parameter int WORD_W     = 6,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_load,
  input  logic [PAGE_W+WORD_W-1:0] addr_in,
  input  logic                     byte_strobe,
  input  logic [DATA_W-1:0]        byte_in,
  input  logic                     stop_strobe,
  input  logic                     wp_in,
  output logic                     busy_out,
  output logic                     mem_we,
  output logic [PAGE_W+WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0]        mem_wdata
);
  localparam int CNT_W = $clog2(CYCLE_CLKS) + 1;
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(1 << WORD_W);

  logic              accept, load_en, byte_en, stop_en, commit_go, buf_clr;
  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, any_valid, cyc_busy, cyc_done, scan_on;
  logic [CNT_W-1:0]  cyc_cnt;

  // every strobe is dropped while the write cycle runs
  assign accept    = !cyc_busy;
  assign load_en   = accept && addr_load;
  assign byte_en   = accept && byte_strobe && !addr_load;
  assign stop_en   = accept && stop_strobe;
  assign commit_go = stop_en && any_valid && !wp_in;
  assign buf_clr   = load_en || (stop_en && !commit_go) || cyc_done;

  pgw_slot_ptr #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_page (addr_in[PAGE_W+WORD_W-1:WORD_W]),
    .load_word (addr_in[WORD_W-1:0]),
    .step_en   (byte_en),
    .page_q    (page_q),
    .word_q    (word_q)
  );

  pgw_slot_store #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (buf_clr),
    .wr_en     (byte_en),
    .wr_idx    (word_q),
    .wr_data   (byte_in),
    .rd_idx    (cyc_cnt[WORD_W-1:0]),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  pgw_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (cyc_busy),
    .done  (cyc_done),
    .count (cyc_cnt)
  );

  // the cycle counter doubles as scan index during the first 2**WORD_W cycles
  assign scan_on   = cyc_busy && (cyc_cnt < SCAN_END);
  assign mem_we    = scan_on && rd_valid;
  assign mem_addr  = {page_q, cyc_cnt[WORD_W-1:0]};
  assign mem_wdata = rd_data;
  assign busy_out  = cyc_busy;
endmodule

// File: rtl/pgw_page_commit_chk.sv
module pgw_page_commit_chk #(
  parameter int PAGE_W     = 9,
  parameter int WORD_W     = 6,
  parameter int CYCLE_CLKS = 250000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     addr_load,
  input logic                     byte_strobe,
  input logic                     stop_strobe,
  input logic                     wp_in,
  input logic                     busy_out,
  input logic                     mem_we,
  input logic [PAGE_W+WORD_W-1:0] mem_addr
);
  int   bcnt_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= 0;
    else        bcnt_q <= busy_out ? bcnt_q + 1 : 0;
  end

  // a byte has been accepted since the last load or idle stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       seen_q <= 1'b0;
    else if (!busy_out && (addr_load || stop_strobe)) seen_q <= 1'b0;
    else if (!busy_out && byte_strobe)                seen_q <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy_out && !mem_we));

  assert_page_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out && $past(busy_out)) |-> $stable(mem_addr[PAGE_W+WORD_W-1:WORD_W]));

  assert_scan_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[WORD_W-1:0] > $past(mem_addr[WORD_W-1:0])));

  assert_commit_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && !busy_out && !wp_in && seen_q && !addr_load) |=> busy_out);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_out) |-> (bcnt_q == CYCLE_CLKS));

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out |-> (bcnt_q < CYCLE_CLKS));

  assert_empty_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && !busy_out && !seen_q) |=> !busy_out);

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && !busy_out && wp_in) |=> !busy_out);

  assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy_out && bcnt_q < (1 << WORD_W)));
endmodule

bind pgw_page_commit pgw_page_commit_chk #(
  .PAGE_W(PAGE_W), .WORD_W(WORD_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_load   (addr_load),
  .byte_strobe (byte_strobe),
  .stop_strobe (stop_strobe),
  .wp_in       (wp_in),
  .busy_out    (busy_out),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr)
);

// File: tb/pgw_page_commit_tb.sv
module pgw_page_commit_tb_top;
  localparam int PAGE_W = 9;
  localparam int WORD_W = 6;
  localparam int CYC    = 100;
  localparam int SLOTS  = 1 << WORD_W;

  logic        clk, rst_n, addr_load, byte_strobe, stop_strobe, wp_in;
  logic [14:0] addr_in;
  logic [7:0]  byte_in;
  logic        busy_out, mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;

  pgw_page_commit #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(8), .CYCLE_CLKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_strobe(byte_strobe), .byte_in(byte_in), .stop_strobe(stop_strobe),
    .wp_in(wp_in), .busy_out(busy_out), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] exp_mem [int];
  logic [7:0] obs_mem [int];
  int wr_cnt = 0, busy_cnt = 0, stray_we = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        obs_mem[int'(mem_addr)] = mem_wdata;
        wr_cnt++;
        if (!busy_out) stray_we++;
      end
      if (busy_out) busy_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_load(input int page, input int word);
    @(negedge clk);
    addr_in = 15'((page << WORD_W) | word); addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] b);
    @(negedge clk);
    byte_in = b; byte_strobe = 1'b1;
    @(negedge clk);
    byte_strobe = 1'b0;
  endtask

  // returns busy as seen right after the stop was taken
  task automatic pulse_stop(output logic busy_after);
    @(negedge clk);
    stop_strobe = 1'b1;
    @(negedge clk);
    busy_after = busy_out;
    stop_strobe = 1'b0;
  endtask

  function automatic int page_mismatch(input int page);
    int m = 0;
    for (int s = 0; s < SLOTS; s++) begin
      int a = (page << WORD_W) | s;
      if (exp_mem.exists(a) != obs_mem.exists(a)) m++;
      else if (exp_mem.exists(a) && exp_mem[a] !== obs_mem[a]) m++;
    end
    return m;
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (busy_out && guard < 4 * CYC) begin
      @(negedge clk); guard++;
    end
    @(negedge clk); #1;
  endtask

  // one write transaction; junk_bytes > 0 first fills another page (R10)
  task automatic do_write(input int page, input int word, input int n, input bit wp,
                          input int junk_bytes, input bit poke_busy);
    logic [7:0] slot_d [SLOTS];
    bit         slot_v [SLOTS];
    int         w = word, nv = 0, w0, b0;
    logic       bsy;
    bit         commit;
    for (int s = 0; s < SLOTS; s++) slot_v[s] = 1'b0;
    if (junk_bytes > 0) begin
      pulse_load((page + 1) % (1 << PAGE_W), 0);
      for (int j = 0; j < junk_bytes; j++) pulse_byte(8'($urandom));
    end
    pulse_load(page, word);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      pulse_byte(b);
      slot_d[w] = b; slot_v[w] = 1'b1;
      w = (w + 1) % SLOTS;
    end
    wp_in = wp;
    w0 = wr_cnt; b0 = busy_cnt;
    pulse_stop(bsy);
    wp_in = 1'b0;
    commit = (n > 0) && !wp;
    if (n == 0)  chk(bsy == 1'b0, "R6 busy after empty stop", bsy, 0);
    else if (wp) chk(bsy == 1'b0, "R7 busy after protected stop", bsy, 0);
    else         chk(bsy == 1'b1, "R5 busy after stop", bsy, 1);
    if (poke_busy && commit) begin
      // strobes during busy must change nothing (R8)
      pulse_load((page + 3) % (1 << PAGE_W), 7);
      pulse_byte(8'hA5);
      pulse_byte(8'h5A);
      pulse_stop(bsy);
    end
    wait_idle();
    for (int s = 0; s < SLOTS; s++)
      if (slot_v[s]) begin
        nv++;
        if (commit) exp_mem[(page << WORD_W) | s] = slot_d[s];
      end
    chk(busy_cnt - b0 == (commit ? CYC : 0), "R5 busy length", busy_cnt - b0, commit ? CYC : 0);
    chk(wr_cnt - w0 == (commit ? nv : 0), "R4 write count", wr_cnt - w0, commit ? nv : 0);
    chk(page_mismatch(page) == 0, "R2 R3 page contents", page_mismatch(page), 0);
    if (junk_bytes > 0)
      chk(page_mismatch((page + 1) % (1 << PAGE_W)) == 0, "R10 dropped bytes",
          page_mismatch((page + 1) % (1 << PAGE_W)), 0);
    if (poke_busy && commit) begin
      w0 = wr_cnt; b0 = busy_cnt;
      pulse_stop(bsy);
      wait_idle();
      chk(bsy == 1'b0 && busy_cnt == b0, "R8 strobes in busy ignored", busy_cnt - b0, 0);
      chk(page_mismatch((page + 3) % (1 << PAGE_W)) == 0, "R8 no write to poked page",
          page_mismatch((page + 3) % (1 << PAGE_W)), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; addr_load = 1'b0; byte_strobe = 1'b0; stop_strobe = 1'b0;
    wp_in = 1'b0; addr_in = '0; byte_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy_out == 1'b0, "R1 busy at reset", busy_out, 0);
    chk(mem_we == 1'b0, "R1 we at reset", mem_we, 0);
    begin
      logic bsy;
      pulse_stop(bsy);
      wait_idle();
      chk(bsy == 1'b0, "R1 empty buffer after reset", bsy, 0);
    end

    do_write(10, 0, 64, 1'b0, 0, 1'b0);   // full page
    do_write(11, 60, 10, 1'b0, 0, 1'b0);  // R3 wrap to slot 0
    do_write(12, 5, 70, 1'b0, 0, 1'b0);   // R3 overwrite within page
    do_write(13, 20, 0, 1'b0, 0, 1'b0);   // R6 address only
    do_write(14, 3, 5, 1'b1, 0, 1'b0);    // R7 protected
    begin
      logic bsy;
      pulse_stop(bsy);                     // R7 bytes discarded
      wait_idle();
      chk(bsy == 1'b0, "R7 discarded after protect", bsy, 0);
    end
    do_write(15, 30, 3, 1'b0, 0, 1'b1);   // R8 poke during busy
    do_write(20, 63, 2, 1'b0, 9, 1'b0);   // R10 reload drops bytes
    do_write(511, 62, 4, 1'b0, 0, 1'b0);  // last page wraps in page

    for (int t = 0; t < 24; t++) begin
      int pg = 100 + ($urandom % 4);
      int wd = $urandom % SLOTS;
      int n  = $urandom % 80;
      bit wp = ($urandom % 8) == 0;
      do_write(pg, wd, n, wp, 0, ($urandom % 4) == 0);
    end

    chk(stray_we == 0, "R9 write outside busy", stray_we, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule